// File: doc/BRIEF.md
# Power Partition Ungate Sequencer

This block powers up numbered power partitions when software asks for it. Software talks to it over a small 32-bit read/write register bus that has two live registers. The request register takes a 5-bit partition number and a start flag. The status register is a bitmap with one bit per implemented partition. A bit reads 1 once its partition is powered. The same bitmap drives the `part_on` outputs toward the power switches.

A request moves through two phases. First it is pending, and the start flag reads 1. On the next cycle the sequencer accepts the request and clears the start flag. It then runs a fixed-length power-up delay. Only at the end of that delay does the partition's status bit set. Because the start flag drops when the sequence begins, software must poll the status bit to learn when the partition is powered. Only one request can be in flight at a time. If a second start arrives too early, the block drops it and raises a sticky error flag. Powering a partition down is modelled only as a write-one-to-clear on the status register.

The processor partitions use numbers 0, 9, 10 and 11. Partition 0 is powered out of reset. A number with no partition behind it is accepted and then dropped without any effect.

Top module: `pgs_top`

## Requirements
- R1: After reset, the status register (word address 1) reads 0x0000_0001, meaning only partition 0 is powered. The request register (word address 0) reads 0.
- R2: A write to word address 0 with bit 8 (start) set, while the block is idle, loads the partition number from bits 4:0. The next read shows start=1 and that number. One cycle later start reads 0.
- R3: The status bit of the requested partition sets exactly SEQ_CYCLES+1 clock edges after the edge that took the write, and not earlier.
- R4: Partitions 0, 9, 10 and 11 can each be powered by a request. A request for a partition that is already powered leaves its status bit at 1.
- R5: A start write made while a request is pending or running is ignored. The stored partition number and the sequence in flight are unchanged, and the error flag (bit 16 of word 0) sets and stays set.
- R6: A write to word 0 with bit 16 set clears the error flag. If the same write is also rejected under R5, the flag stays set.
- R7: A request for a partition number at or above NUM_PARTS clears start one cycle after it shows. No status bit changes, and a new request is accepted right after.
- R8: A write to word address 1 clears every status bit written as 1. Bits written as 0 keep their value.
- R9: If a status clear write lands on the same edge that a sequence completes, the completing partition's bit ends at 1. The other bits named in the clear still clear.
- R10: A write to word 0 with bit 8 clear starts nothing and leaves the stored partition number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address: 0 is the request register, 1 is the status register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read strobe |
| bus_rvalid | output | 1 | High when bus_rdata holds a read result |
| part_on | output | NUM_PARTS | Power-on state of each partition (the status bitmap) |

## Verification
Two events can touch the status bitmap on the same edge: the sequencer's completion, which sets a bit, and a software clear write. The bench counts edges from the accepting write and places a clear of both the completing bit and partition 0 on the exact completion edge. It then expects the completing bit to read 1 and partition 0 to read 0. A second overlap affects the error flag: a write that sets start and also clears the error while a request is still pending. The read that follows must show the flag still set.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int PID_W     = 5;
  localparam int START_BIT = 8;
  localparam int ERR_BIT   = 16;
  localparam logic [ADDR_W-1:0] ADDR_TOGGLE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd1;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PEND = 2'd1,
    SQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pgs_rst_sync.sv
module pgs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pgs_seq.sv
module pgs_seq
  import pgs_pkg::*;
#(
  parameter int NUM_PARTS  = 16,
  parameter int SEQ_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [PID_W-1:0] req_pid_i,
  output logic             start_o,
  output logic [PID_W-1:0] pid_o,
  output logic             reject_o,
  output logic             done_o
);
  localparam int CNT_W = (SEQ_CYCLES > 1) ? $clog2(SEQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SEQ_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PID_W-1:0] pid_q;
  logic             cnt_en, pid_en, accept, pid_valid;

  assign pid_valid = (32'(pid_q) < NUM_PARTS);
  assign accept    = req_i && (state_q == SQ_IDLE);
  assign reject_o  = req_i && (state_q != SQ_IDLE);
  assign done_o    = (state_q == SQ_RUN) && (cnt_q == '0);
  assign start_o   = (state_q == SQ_PEND);
  assign pid_o     = pid_q;
  assign pid_en    = accept;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      SQ_IDLE: if (accept) state_d = SQ_PEND;
      SQ_PEND: begin
        if (pid_valid) begin
          state_d = SQ_RUN;
          cnt_d   = CNT_LOAD;
          cnt_en  = 1'b1;
        end else begin
          state_d = SQ_IDLE;
        end
      end
      SQ_RUN: begin
        if (cnt_q == '0) begin
          state_d = SQ_IDLE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      pid_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (pid_en) pid_q <= req_pid_i;
    end
  end

  // R2: start is visible for exactly one cycle
  p_pend_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SQ_PEND |=> state_q != SQ_PEND);
  // R3: counter stays inside the programmed window
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SQ_RUN |-> cnt_q <= CNT_LOAD);
  // R5: stored partition number is frozen while a request is in flight
  p_pid_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != SQ_IDLE |=> $stable(pid_q));
  // R7: an unimplemented number never starts the delay
  p_bad_pid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_PEND && !pid_valid) |=> state_q == SQ_IDLE);
endmodule

// File: rtl/pgs_status.sv
module pgs_status
  import pgs_pkg::*;
#(
  parameter int NUM_PARTS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en_i,
  input  logic [PID_W-1:0]     set_idx_i,
  input  logic                 clr_en_i,
  input  logic [NUM_PARTS-1:0] clr_mask_i,
  output logic [NUM_PARTS-1:0] status_o
);
  localparam logic [NUM_PARTS-1:0] RESET_VAL = NUM_PARTS'(1);

  logic [NUM_PARTS-1:0] st_q, st_d, set_vec, clr_vec;
  logic                 st_en;

  for (genvar g = 0; g < NUM_PARTS; g++) begin : g_bit
    assign set_vec[g] = set_en_i && (set_idx_i == PID_W'(g));
    assign clr_vec[g] = clr_en_i && clr_mask_i[g];
    // completion dominates a clear on the same edge
    assign st_d[g]    = set_vec[g] | (st_q[g] & ~clr_vec[g]);
  end

  assign st_en    = set_en_i || clr_en_i;
  assign status_o = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= RESET_VAL;
    else if (st_en) st_q <= st_d;
  end

  // R3: a status bit rises only on a completion
  p_rise_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    |(st_q & ~$past(st_q)) |-> $past(set_en_i));
  // R8: a status bit falls only on a clear write
  p_fall_needs_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(st_q) & ~st_q) |-> $past(clr_en_i));
  // R9: the completing bit is set even if a clear hits it
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_en_i) |-> ((st_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/pgs_top.sv
module pgs_top
  import pgs_pkg::*;
#(
  parameter int NUM_PARTS  = 16,
  parameter int SEQ_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_PARTS-1:0] part_on
);
  logic                 rst_s_n;
  logic                 tog_wr, st_wr, req, err_clr;
  logic                 start, reject, done;
  logic [PID_W-1:0]     pid;
  logic [NUM_PARTS-1:0] status;
  logic                 err_q, err_d;
  logic [DATA_W-1:0]    rd_mux, rdata_q;
  logic                 rvalid_q;
  logic                 unused_wdata;

  pgs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  assign tog_wr       = bus_wr && (bus_addr == ADDR_TOGGLE);
  assign st_wr        = bus_wr && (bus_addr == ADDR_STATUS);
  assign req          = tog_wr && bus_wdata[START_BIT];
  assign err_clr      = tog_wr && bus_wdata[ERR_BIT];
  assign unused_wdata = ^bus_wdata;

  pgs_seq #(.NUM_PARTS(NUM_PARTS), .SEQ_CYCLES(SEQ_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_s_n),
    .req_i(req), .req_pid_i(bus_wdata[PID_W-1:0]),
    .start_o(start), .pid_o(pid), .reject_o(reject), .done_o(done)
  );

  pgs_status #(.NUM_PARTS(NUM_PARTS)) u_status (
    .clk(clk), .rst_n(rst_s_n),
    .set_en_i(done), .set_idx_i(pid),
    .clr_en_i(st_wr), .clr_mask_i(bus_wdata[NUM_PARTS-1:0]),
    .status_o(status)
  );

  always_comb begin
    err_d = err_q;
    if (reject)       err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_TOGGLE) begin
      rd_mux[PID_W-1:0] = pid;
      rd_mux[START_BIT] = start;
      rd_mux[ERR_BIT]   = err_q;
    end else if (bus_addr == ADDR_STATUS) begin
      rd_mux[NUM_PARTS-1:0] = status;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      err_q    <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      err_q    <= err_d;
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign part_on    = status;

  // R5: a rejected start always leaves the error flag set
  p_reject_sets_err_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    reject |=> err_q);
  // R6: the error flag only drops on an explicit clear
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: tb/pgs_top_tb_top.sv
module pgs_top_tb_top;
  localparam int NP = 16;
  localparam int N  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NP-1:0] part_on;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pgs_top #(.NUM_PARTS(NP), .SEQ_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .part_on(part_on)
  );

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops expected values as read results appear
  always @(negedge clk) begin
    if (bus_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data: actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    rd(0, 32'h0, "R1 request reg after reset");
    rd(1, 32'h1, "R1 status after reset");
    // R2 / R3 / R4: partition 9 with exact completion edge
    wr(0, 32'h109);
    rd(0, 32'h109, "R2 start visible");
    rd(0, 32'h009, "R2 start cleared");
    idle(N - 2);
    rd(1, 32'h1,   "R3 status not yet set");
    rd(1, 32'h201, "R3 status set on time");
    // R4 remaining processor partitions
    wr(0, 32'h10A); idle(N + 1); rd(1, 32'h601, "R4 partition 10");
    wr(0, 32'h10B); idle(N + 1); rd(1, 32'hE01, "R4 partition 11");
    wr(0, 32'h100); idle(N + 1); rd(1, 32'hE01, "R4 partition 0 already on");
    // R8 clear
    wr(1, 32'hE00);
    rd(1, 32'h1, "R8 write-one-to-clear");
    // R9 clear on the completion edge
    wr(0, 32'h10C); idle(N);
    wr(1, 32'h1001);
    rd(1, 32'h1000, "R9 completion beats clear");
    // R5 rejects while pending and while running
    wr(0, 32'h105);
    wr(0, 32'h106);
    rd(0, 32'h10005, "R5 reject while pending");
    wr(0, 32'h107);
    idle(N);
    rd(1, 32'h1020, "R5 only original partition powered");
    rd(0, 32'h10005, "R5 error sticky");
    // R6 clear and set-wins
    wr(0, 32'h10000);
    rd(0, 32'h00005, "R6 error cleared");
    wr(0, 32'h108);
    wr(0, 32'h10109);
    rd(0, 32'h10008, "R6 reject beats clear");
    idle(N);
    rd(1, 32'h1120, "R6 partition 8 powered");
    wr(0, 32'h10000);
    rd(0, 32'h00008, "R6 error cleared again");
    // R7 unimplemented partition
    wr(0, 32'h114);
    rd(0, 32'h114, "R7 start visible");
    rd(0, 32'h014, "R7 start cleared");
    wr(0, 32'h103);
    rd(0, 32'h103, "R7 next request accepted");
    idle(N + 1);
    rd(1, 32'h1128, "R7 no stray status bit");
    // R10 write without start
    wr(0, 32'h00E);
    rd(0, 32'h003, "R10 number unchanged");
    idle(N + 2);
    rd(1, 32'h1128, "R10 nothing powered");
    idle(3);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1-scoreboard drain: actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule